// File: doc/BRIEF.md
# MAC Control and Status Register Bank

This block is the software-visible register bank of an Ethernet MAC controller. It sits on a 32-bit, word-addressed request/response port and holds the controller's configuration words: operating mode, interrupt events and their enables, the three inter-frame gap settings, frame length limits, collision settings, the transmit descriptor count, a control-frame mode word, six management-interface words, a two-word station address and a two-word multicast hash. Above these registers, the same port opens a window onto the descriptor RAM.

The block applies its reset defaults and its write side effects. The interrupt-event word is cleared by writing ones to it. Writing the transmit descriptor count also moves the receive ring start index. Setting the soft-reset bit in a mode write reloads every register default. Hardware event pulses from the MAC datapath set interrupt bits directly. `irq` is the OR of the pending events that are enabled.

Requests use a valid/ready handshake. `req_ready` is held high, so a request is taken in every cycle where `req_valid` is high. Each accepted request returns exactly one response one cycle later. The response has no back-pressure, so the requester must always be able to take it. Misaligned or unmapped accesses return an error response and read data of zero.

Top module: `macctl_regfile`

## Requirements
- R1: After reset, reads return these values at these word offsets (byte address = 4 × offset):
  - 0 mode = 0x0000A000
  - 3 back-to-back gap = 0x12
  - 4 gap part one = 0x0C
  - 5 gap part two = 0x12
  - 6 frame limits = 0x003C0600 (minimum in bits 31:16, maximum in bits 15:0)
  - 7 collision settings = 0x000F003F
  - 8 transmit descriptor count = 0x40
  - 10 management clock mode = 0x64
  - Offsets 1, 2, 9 and 11–19 read 0.
- R2: A write to offset 1 (interrupt events) clears each bit that is written as 1 and leaves every bit written as 0 unchanged.
- R3: Bit i of `irq_set` set in a cycle sets event bit i. This holds even when a same-cycle write clears that bit, because setting wins. `irq` is high exactly when some event bit (low 7 bits) is set whose enable bit at offset 2 is also set.
- R4: A write to offset 8 keeps only data bits 7:0, and reads return the upper bits as zero. `rx_ring_idx` becomes twice the stored value. After reset `rx_ring_idx` is 0x80.
- R5: Offset 16 holds station address bytes 3,2,1,0 from bit 31 down to bit 0. Offset 17 holds bytes 5,4 in bits 15:0, and its bits 31:16 read as zero. `mac_addr` is {offset17[15:0], offset16}.
- R6: A write to offset 0 with data bit 11 set returns all registers, the interrupt events and `rx_ring_idx` to their R1 values, and the mode reads 0x0000A000. Descriptor RAM contents are kept. A mode write with bit 11 clear is stored as written and drives `mode_q`.
- R7: Byte addresses 0x400 + 4k, for k from 0 to 127, read and write descriptor RAM word k.
- R8: A request with address bits 1:0 not zero returns `rsp_err` = 1 and `rsp_rdata` = 0, and changes no register or RAM word.
- R9: Word offsets 20–255 and 384–511 are unmapped. A request there returns `rsp_err` = 1 and `rsp_rdata` = 0, and changes nothing.
- R10: `req_ready` is always 1. A request accepted at a clock edge gives `rsp_valid` = 1 for the following cycle. A write response carries `rsp_rdata` = 0 and `rsp_err` = 0. With no request accepted, `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Rejected access |
| irq_set | input | 7 | Event pulses from the MAC datapath |
| irq | output | 1 | Enabled event pending |
| mode_q | output | 32 | Current mode word |
| mac_addr | output | 48 | Station address, byte 5 in the top bits |
| rx_ring_idx | output | 9 | Receive ring start index |

## Verification
The functions that can land in the same cycle are a software write-one-to-clear of the interrupt-event word and a hardware event pulse. The bench drives `irq_set` during the very cycle in which the clearing write is accepted, with both naming the same bit. It then reads the word back and expects the pulsed bit to survive while the other written bits are cleared. A soft reset is also issued after events have been raised, to show that the reload takes priority over pending event state.

// File: rtl/macctl_pkg.sv
package macctl_pkg;

  localparam int NUM_REGS = 20;

  localparam int OFF_MODE       = 0;
  localparam int OFF_IRQ_SRC    = 1;
  localparam int OFF_IRQ_EN     = 2;
  localparam int OFF_GAP_B2B    = 3;
  localparam int OFF_GAP_P1     = 4;
  localparam int OFF_GAP_P2     = 5;
  localparam int OFF_FRAME_LIM  = 6;
  localparam int OFF_COLL_CFG   = 7;
  localparam int OFF_TXDESC_CNT = 8;
  localparam int OFF_CTRL_MODE  = 9;
  localparam int OFF_MGMT_MODE  = 10;
  localparam int OFF_STA_LO     = 16;
  localparam int OFF_STA_HI     = 17;

  localparam int SOFT_RST_BIT = 11;

  typedef enum logic [1:0] {
    ACC_REG  = 2'd0,
    ACC_DESC = 2'd1,
    ACC_BAD  = 2'd2
  } acc_kind_e;

  function automatic logic [31:0] reg_default(int idx);
    case (idx)
      OFF_MODE:       return 32'h0000_A000;
      OFF_GAP_B2B:    return 32'h0000_0012;
      OFF_GAP_P1:     return 32'h0000_000C;
      OFF_GAP_P2:     return 32'h0000_0012;
      OFF_FRAME_LIM:  return 32'h003C_0600;
      OFF_COLL_CFG:   return 32'h000F_003F;
      OFF_TXDESC_CNT: return 32'h0000_0040;
      OFF_MGMT_MODE:  return 32'h0000_0064;
      default:        return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] reg_wmask(int idx);
    case (idx)
      OFF_TXDESC_CNT: return 32'h0000_00FF;
      OFF_STA_HI:     return 32'h0000_FFFF;
      default:        return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/macctl_decode.sv
module macctl_decode
  import macctl_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int NREG       = 20,
  parameter int DESC_BASE  = 256,
  parameter int DESC_WORDS = 128,
  localparam int REG_AW    = $clog2(NREG),
  localparam int DESC_AW   = $clog2(DESC_WORDS)
) (
  input  logic [ADDR_W-1:0]  addr,
  output acc_kind_e          kind,
  output logic [REG_AW-1:0]  reg_idx,
  output logic [DESC_AW-1:0] desc_idx
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W:0] REG_END = (WORD_W+1)'(NREG);
  localparam logic [WORD_W:0] DESC_LO = (WORD_W+1)'(DESC_BASE);
  localparam logic [WORD_W:0] DESC_HI = (WORD_W+1)'(DESC_BASE + DESC_WORDS);

  logic [WORD_W:0] word_ext;
  logic [WORD_W:0] desc_off;
  logic            aligned;
  logic            in_regs;
  logic            in_desc;

  assign word_ext = {1'b0, addr[ADDR_W-1:2]};
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_regs  = (word_ext < REG_END);
  assign in_desc  = (word_ext >= DESC_LO) && (word_ext < DESC_HI);
  assign desc_off = word_ext - DESC_LO;
  assign desc_idx = desc_off[DESC_AW-1:0];
  assign reg_idx  = word_ext[REG_AW-1:0];

  always_comb begin
    if (!aligned)     kind = ACC_BAD;
    else if (in_regs) kind = ACC_REG;
    else if (in_desc) kind = ACC_DESC;
    else              kind = ACC_BAD;
  end

endmodule

// File: rtl/macctl_csr.sv
module macctl_csr
  import macctl_pkg::*;
#(
  parameter int NREG    = 20,
  parameter int IRQ_W   = 7,
  localparam int REG_AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [REG_AW-1:0] rd_idx,
  output logic [31:0]       rd_data,
  input  logic [IRQ_W-1:0]  irq_set,
  output logic              irq,
  output logic [31:0]       mode_q,
  output logic [47:0]       mac_addr,
  output logic [8:0]        rx_ring_idx
);

  localparam logic [31:0] SRC_MASK = 32'((64'd1 << IRQ_W) - 64'd1);
  localparam logic [8:0]  RING_RST = {reg_default(OFF_TXDESC_CNT)[7:0], 1'b0};

  logic [31:0] regs_q [NREG];
  logic        soft_rst;
  logic [31:0] set_ext;

  assign soft_rst = wr_en && (wr_idx == REG_AW'(OFF_MODE)) && wr_data[SOFT_RST_BIT];
  assign set_ext  = 32'(irq_set);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == REG_AW'(i));
    if (i == OFF_IRQ_SRC) begin : g_events
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        regs_q[i] <= reg_default(i);
        else if (soft_rst) regs_q[i] <= reg_default(i);
        else               regs_q[i] <= ((regs_q[i] & ~(hit ? wr_data : 32'h0)) | set_ext) & SRC_MASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        regs_q[i] <= reg_default(i);
        else if (soft_rst) regs_q[i] <= reg_default(i);
        else if (hit)      regs_q[i] <= wr_data & reg_wmask(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_ring_idx <= RING_RST;
    else if (soft_rst) rx_ring_idx <= RING_RST;
    else if (wr_en && (wr_idx == REG_AW'(OFF_TXDESC_CNT)))
      rx_ring_idx <= {wr_data[7:0], 1'b0};
  end

  assign rd_data  = (int'(rd_idx) < NREG) ? regs_q[rd_idx] : 32'h0;
  assign irq      = |(regs_q[OFF_IRQ_SRC][IRQ_W-1:0] & regs_q[OFF_IRQ_EN][IRQ_W-1:0]);
  assign mode_q   = regs_q[OFF_MODE];
  assign mac_addr = {regs_q[OFF_STA_HI][15:0], regs_q[OFF_STA_LO]};

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == REG_AW'(OFF_IRQ_SRC) && !soft_rst && irq_set == '0)
      |=> ((regs_q[OFF_IRQ_SRC] & $past(wr_data)) == 32'h0)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq_set) && !soft_rst)
      |=> ((regs_q[OFF_IRQ_SRC][IRQ_W-1:0] & $past(irq_set)) == $past(irq_set))); // R3
  AST_RING_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == REG_AW'(OFF_TXDESC_CNT) && !soft_rst)
      |=> (rx_ring_idx == {$past(wr_data[7:0]), 1'b0})); // R4
  AST_SOFT_RST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode_q == reg_default(OFF_MODE) && rx_ring_idx == RING_RST)); // R6

endmodule

// File: rtl/macctl_desc_ram.sv
module macctl_desc_ram #(
  parameter int WORDS = 128,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/macctl_regfile.sv
module macctl_regfile
  import macctl_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DESC_BASE  = 256,
  parameter int DESC_WORDS = 128,
  parameter int IRQ_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic [IRQ_W-1:0]  irq_set,
  output logic              irq,
  output logic [31:0]       mode_q,
  output logic [47:0]       mac_addr,
  output logic [8:0]        rx_ring_idx
);

  localparam int REG_AW  = $clog2(NUM_REGS);
  localparam int DESC_AW = $clog2(DESC_WORDS);

  acc_kind_e           kind;
  logic [REG_AW-1:0]   reg_idx;
  logic [DESC_AW-1:0]  desc_idx;
  logic [31:0]         csr_rd;
  logic [31:0]         ram_rd;
  logic                accept;
  logic                csr_we;
  logic                ram_en;
  logic                rd_reg_q;
  logic                rd_ram_q;
  logic [31:0]         reg_data_q;

  assign req_ready = 1'b1;
  assign accept    = req_valid;
  assign csr_we    = accept && req_write && (kind == ACC_REG);
  assign ram_en    = accept && (kind == ACC_DESC);

  macctl_decode #(
    .ADDR_W(ADDR_W), .NREG(NUM_REGS),
    .DESC_BASE(DESC_BASE), .DESC_WORDS(DESC_WORDS)
  ) u_decode (
    .addr(req_addr), .kind(kind), .reg_idx(reg_idx), .desc_idx(desc_idx)
  );

  macctl_csr #(.NREG(NUM_REGS), .IRQ_W(IRQ_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(csr_we), .wr_idx(reg_idx), .wr_data(req_wdata),
    .rd_idx(reg_idx), .rd_data(csr_rd),
    .irq_set(irq_set), .irq(irq),
    .mode_q(mode_q), .mac_addr(mac_addr), .rx_ring_idx(rx_ring_idx)
  );

  macctl_desc_ram #(.WORDS(DESC_WORDS)) u_ram (
    .clk(clk), .en(ram_en), .we(req_write),
    .addr(desc_idx), .wdata(req_wdata), .rdata(ram_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rd_reg_q   <= 1'b0;
      rd_ram_q   <= 1'b0;
      reg_data_q <= 32'h0;
    end else begin
      rsp_valid  <= accept;
      rsp_err    <= accept && (kind == ACC_BAD);
      rd_reg_q   <= accept && !req_write && (kind == ACC_REG);
      rd_ram_q   <= accept && !req_write && (kind == ACC_DESC);
      reg_data_q <= csr_rd;
    end
  end

  always_comb begin
    if (rd_reg_q)      rsp_rdata = reg_data_q;
    else if (rd_ram_q) rsp_rdata = ram_rd;
    else               rsp_rdata = 32'h0;
  end

  AST_ERR_HAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R8
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'h0)); // R9
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R10

endmodule

// File: tb/macctl_regfile_bench.sv
module macctl_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [6:0]  irq_set = '0;
  logic        irq;
  logic [31:0] mode_q;
  logic [47:0] mac_addr;
  logic [8:0]  rx_ring_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  macctl_regfile u_macctl_regfile (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq_set(irq_set), .irq(irq), .mode_q(mode_q),
    .mac_addr(mac_addr), .rx_ring_idx(rx_ring_idx)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [10:0] a, input logic [31:0] d,
                        input logic [6:0] ev, output logic [31:0] rd, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; irq_set = ev;
    @(negedge clk);
    chk("R10", "rsp_valid after request", 64'(rsp_valid), 64'd1);
    rd = rsp_rdata; err = rsp_err;
    req_valid = 1'b0; req_write = 1'b0; irq_set = '0;
  endtask

  task automatic wr_ok(logic [10:0] a, logic [31:0] d, string req);
    logic [31:0] rd; logic err;
    access(1'b1, a, d, '0, rd, err);
    chk(req, "write err", 64'(err), 64'd0);
    chk("R10", "write rdata", 64'(rd), 64'd0);
  endtask

  task automatic rd_exp(logic [10:0] a, logic [31:0] exp, string req);
    logic [31:0] rd; logic err;
    access(1'b0, a, 32'h0, '0, rd, err);
    chk(req, $sformatf("read 0x%0h", a), 64'(rd), 64'(exp));
    chk(req, "read err", 64'(err), 64'd0);
  endtask

  task automatic t_reset();
    logic [31:0] exp;
    for (int i = 0; i < 20; i++) begin
      case (i)
        0: exp = 32'h0000A000; 3: exp = 32'h12; 4: exp = 32'h0C; 5: exp = 32'h12;
        6: exp = 32'h003C0600; 7: exp = 32'h000F003F; 8: exp = 32'h40; 10: exp = 32'h64;
        default: exp = 32'h0;
      endcase
      rd_exp(11'(i * 4), exp, "R1");
    end
    chk("R4", "ring idx after reset", 64'(rx_ring_idx), 64'h80);
    chk("R1", "mode_q after reset", 64'(mode_q), 64'hA000);
    chk("R3", "irq after reset", 64'(irq), 64'd0);
    chk("R10", "req_ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_w1c();
    logic [31:0] rd; logic err;
    access(1'b0, 11'h010, 32'h0, 7'h55, rd, err);
    rd_exp(11'h004, 32'h55, "R3");
    wr_ok(11'h004, 32'h05, "R2");
    rd_exp(11'h004, 32'h50, "R2");
    wr_ok(11'h004, 32'h00, "R2");
    rd_exp(11'h004, 32'h50, "R2");
  endtask

  task automatic t_set_vs_clear();
    logic [31:0] rd; logic err;
    access(1'b1, 11'h004, 32'h50, 7'h10, rd, err);
    rd_exp(11'h004, 32'h10, "R3");
    wr_ok(11'h008, 32'h10, "R3");
    @(negedge clk);
    chk("R3", "irq with enabled event", 64'(irq), 64'd1);
    wr_ok(11'h008, 32'h01, "R3");
    @(negedge clk);
    chk("R3", "irq with disabled event", 64'(irq), 64'd0);
  endtask

  task automatic t_txdesc();
    wr_ok(11'h020, 32'h123456C3, "R4");
    rd_exp(11'h020, 32'hC3, "R4");
    chk("R4", "ring idx after count write", 64'(rx_ring_idx), 64'h186);
  endtask

  task automatic t_station();
    wr_ok(11'h040, 32'h44332211, "R5");
    wr_ok(11'h044, 32'hABCD6655, "R5");
    rd_exp(11'h044, 32'h6655, "R5");
    chk("R5", "mac_addr", 64'(mac_addr), 64'h665544332211);
  endtask

  task automatic t_desc();
    wr_ok(11'h400, 32'hCAFE0001, "R7");
    wr_ok(11'h5FC, 32'hBEEF007F, "R7");
    wr_ok(11'h404, 32'h00000011, "R7");
    rd_exp(11'h400, 32'hCAFE0001, "R7");
    rd_exp(11'h5FC, 32'hBEEF007F, "R7");
    rd_exp(11'h404, 32'h00000011, "R7");
  endtask

  task automatic t_misaligned();
    logic [31:0] rd; logic err;
    access(1'b1, 11'h00D, 32'h77, '0, rd, err);
    chk("R8", "misaligned write err", 64'(err), 64'd1);
    rd_exp(11'h00C, 32'h12, "R8");
    access(1'b0, 11'h402, 32'h0, '0, rd, err);
    chk("R8", "misaligned read err", 64'(err), 64'd1);
    chk("R8", "misaligned read data", 64'(rd), 64'd0);
    access(1'b1, 11'h401, 32'h99, '0, rd, err);
    chk("R8", "misaligned desc write err", 64'(err), 64'd1);
    rd_exp(11'h400, 32'hCAFE0001, "R8");
  endtask

  task automatic t_unmapped();
    logic [31:0] rd; logic err;
    access(1'b0, 11'h050, 32'h0, '0, rd, err);
    chk("R9", "offset 20 read err", 64'(err), 64'd1);
    chk("R9", "offset 20 read data", 64'(rd), 64'd0);
    access(1'b1, 11'h3FC, 32'h1234, '0, rd, err);
    chk("R9", "offset 255 write err", 64'(err), 64'd1);
    access(1'b1, 11'h600, 32'h5678, '0, rd, err);
    chk("R9", "offset 384 write err", 64'(err), 64'd1);
    rd_exp(11'h5FC, 32'hBEEF007F, "R9");
    rd_exp(11'h400, 32'hCAFE0001, "R9");
    @(negedge clk);
    chk("R10", "no response when idle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] rd; logic err;
    wr_ok(11'h000, 32'h00000003, "R6");
    chk("R6", "mode_q plain write", 64'(mode_q), 64'h3);
    rd_exp(11'h00C, 32'h12, "R6");
    wr_ok(11'h00C, 32'h99, "R6");
    wr_ok(11'h048, 32'hDEAD, "R6");
    access(1'b0, 11'h010, 32'h0, 7'h7F, rd, err);
    wr_ok(11'h000, 32'h00000803, "R6");
    rd_exp(11'h000, 32'h0000A000, "R6");
    rd_exp(11'h00C, 32'h12, "R6");
    rd_exp(11'h048, 32'h0, "R6");
    rd_exp(11'h004, 32'h0, "R6");
    rd_exp(11'h020, 32'h40, "R6");
    chk("R6", "ring idx after soft reset", 64'(rx_ring_idx), 64'h80);
    chk("R6", "mac_addr after soft reset", 64'(mac_addr), 64'h0);
    rd_exp(11'h400, 32'hCAFE0001, "R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_w1c();
    t_set_vs_clear();
    t_txdesc();
    t_station();
    t_desc();
    t_misaligned();
    t_unmapped();
    t_soft_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule